// File: doc/BRIEF.md
# Biphase Mark Line Receiver

This block takes a single asynchronous serial line carrying biphase-mark-coded data and recovers the bit stream using only a fast local system clock. In this coding the line flips level at every bit boundary, and a one bit flips it a second time halfway through. The receiver is never told the data rate. It times the gaps between line transitions, takes the smallest gap it has seen as the half-bit period, and finds the bit-boundary phase from the first full-bit gap. A full-bit gap can only come from a zero bit, so both of its edges are true boundaries.

Once aligned, the receiver raises a locked flag. It then reports one decoded bit per bit period with a single-cycle valid pulse. Two consecutive short gaps decode as a one. One long gap decodes as a zero. A second counter divides the recovered bit pulses by a bits-per-sample setting to give a per-sample strobe. Framing above the bit level is handled elsewhere.

Top module: `bmcRx`

## Requirements
- R1: While reset is held and in the first cycle after it, `locked`, `bitValid` and `sampleStrobe` are all 0.
- R2: With no rate setting, the receiver locks at any half-bit period from 5 to 20 clock cycles. It needs at least one one bit, then a zero bit. `locked` rises at the boundary that ends that zero bit.
- R3: A stream made only of zero bits never raises `locked` and produces no `bitValid` pulse.
- R4: After lock, each bit period that starts at or after the locking boundary gives exactly one `bitValid` pulse at the edge that ends the bit. `bitData` is 1 for a bit with a mid-period transition and 0 for one without. Bits come out in line order.
- R5: `bitValid` is only ever 1 while `locked` is 1.
- R6: `sampleStrobe` pulses together with the `bitValid` of every Nth bit counted from lock, where N = `bitsPerSample`. A setting of 0 or 1 strobes every bit. The count restarts from zero each time lock is lost.
- R7: After lock, a short gap followed by a long gap clears `locked` and emits no bit for that period. The receiver keeps its learned rate and locks again at the next full-bit gap. No new one bit is needed.
- R8: While locked, if the line stays still for 2.5 half-bit periods or more, `locked` drops. Rate learning then starts again from scratch.
- R9: Between restarts of rate learning, the learned half-bit count never increases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the line bit rate |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Asynchronous biphase-mark-coded serial line |
| bitsPerSample | input | BPS_W | Number of bits per sample for the sample strobe divider |
| bitData | output | 1 | Value of the most recently decoded bit |
| bitValid | output | 1 | One-cycle pulse when `bitData` carries a new bit |
| sampleStrobe | output | 1 | One-cycle pulse on the last bit of each sample |
| locked | output | 1 | High while the receiver is aligned to bit boundaries |

## Verification
The assertions assume a clean line with no glitches. Every transition must be at least a few system-clock cycles from the previous one. The half-bit period must be far below the interval counter limit, and `bitsPerSample` must stay constant while locked. The stimulus meets these conditions. It toggles the line one nanosecond after a clock edge, spaces transitions by whole multiples of a fixed half-bit period between 5 and 20 cycles, and changes `bitsPerSample` only while reset is held. The only coding violation it injects is the short-then-long pattern that R7 defines.

// File: rtl/bmcPkg.sv
package bmcPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEARN = 2'd1,
    ST_LOCK  = 2'd2
  } bmcStateT;

  typedef struct packed {
    logic restart;   // reset the learned half-bit count to its maximum
    logic learn;     // allow the half-bit count to shrink on this edge
    logic emit;      // a decoded bit is ready
    logic emitVal;   // value of that bit
    logic divClear;  // hold the sample divider at zero
  } bmcCtrlT;

endpackage

// File: rtl/bmcDatapath.sv
module bmcDatapath
  import bmcPkg::*;
#(
  parameter int CNT_W = 10,
  parameter int BPS_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic [BPS_W-1:0] bitsPerSample,
  input  bmcCtrlT          ctrl,
  output logic             edgeSeen,
  output logic             isShort,
  output logic             isLong,
  output logic             stalled,
  output logic             bitData,
  output logic             bitValid,
  output logic             sampleStrobe
);

  localparam int WIDE = CNT_W + 3;

  logic [2:0]       syncQ;
  logic [CNT_W-1:0] gapCnt;
  logic [CNT_W-1:0] halfReg;
  logic [WIDE-1:0]  gapW;
  logic [WIDE-1:0]  halfW;
  logic [BPS_W-1:0] bitCount;
  logic             lastBit;

  // two-flop synchronizer plus one delay stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], lineIn};
  end

  assign edgeSeen = syncQ[2] ^ syncQ[1];

  // cycles since last edge, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                 gapCnt <= '0;
    else if (edgeSeen)         gapCnt <= '0;
    else if (gapCnt != '1)     gapCnt <= gapCnt + 1'b1;
  end

  assign gapW  = WIDE'(gapCnt) + WIDE'(1);
  assign halfW = WIDE'(halfReg);

  assign isShort = (gapW + gapW) < (halfW + halfW + halfW);
  assign stalled = (gapW + gapW) >= ((halfW << 2) + halfW);
  assign isLong  = !isShort && !stalled;

  // learned half-bit period: running minimum of edge spacing
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.restart)                  halfReg <= '1;
    else if (ctrl.learn && edgeSeen && gapW < halfW) halfReg <= gapW[CNT_W-1:0];
  end

  // sample divider
  assign lastBit = ({1'b0, bitCount} + 1'b1) >= {1'b0, bitsPerSample};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount     <= '0;
      bitValid     <= 1'b0;
      bitData      <= 1'b0;
      sampleStrobe <= 1'b0;
    end else begin
      bitValid     <= ctrl.emit;
      sampleStrobe <= ctrl.emit && lastBit && !ctrl.divClear;
      if (ctrl.emit) bitData <= ctrl.emitVal;
      if (ctrl.divClear)  bitCount <= '0;
      else if (ctrl.emit) bitCount <= lastBit ? '0 : bitCount + 1'b1;
    end
  end

  AST_HALF_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.restart |=> halfReg <= $past(halfReg)); // R9

endmodule

// File: rtl/bmcControl.sv
module bmcControl
  import bmcPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    edgeSeen,
  input  logic    isShort,
  input  logic    isLong,
  input  logic    stalled,
  output bmcCtrlT ctrl,
  output logic    locked
);

  bmcStateT state, stateNext;
  logic     midPending, midNext;

  always_comb begin
    stateNext    = state;
    midNext      = midPending;
    ctrl         = '0;
    ctrl.restart = (state == ST_IDLE);
    ctrl.learn   = (state == ST_LEARN);
    ctrl.divClear = (state != ST_LOCK);
    case (state)
      ST_IDLE: begin
        midNext = 1'b0;
        if (edgeSeen) stateNext = ST_LEARN;
      end
      ST_LEARN: begin
        midNext = 1'b0;
        if (edgeSeen && isLong) stateNext = ST_LOCK;
      end
      ST_LOCK: begin
        if (edgeSeen) begin
          if (isShort && !midPending) begin
            midNext = 1'b1;
          end else if (isShort) begin
            midNext      = 1'b0;
            ctrl.emit    = 1'b1;
            ctrl.emitVal = 1'b1;
          end else if (isLong && !midPending) begin
            ctrl.emit    = 1'b1;
            ctrl.emitVal = 1'b0;
          end else if (isLong) begin
            stateNext = ST_LEARN;       // coding error, keep rate
            midNext   = 1'b0;
          end else begin
            stateNext = ST_IDLE;        // gap too long
            midNext   = 1'b0;
          end
        end else if (stalled) begin
          stateNext = ST_IDLE;
          midNext   = 1'b0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      midPending <= 1'b0;
    end else begin
      state      <= stateNext;
      midPending <= midNext;
    end
  end

  assign locked = (state == ST_LOCK);

  AST_LOCK_FROM_LEARN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(state) == ST_LEARN); // R2

  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (locked && midPending && edgeSeen && isLong) |=> (!locked && state == ST_LEARN)); // R7

  AST_STALL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !edgeSeen && stalled) |=> (state == ST_IDLE)); // R8

endmodule

// File: rtl/bmcRx.sv
module bmcRx
  import bmcPkg::*;
#(
  parameter int CNT_W = 10,
  parameter int BPS_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic [BPS_W-1:0] bitsPerSample,
  output logic             bitData,
  output logic             bitValid,
  output logic             sampleStrobe,
  output logic             locked
);

  bmcCtrlT ctrl;
  logic    edgeSeen, isShort, isLong, stalled;

  bmcDatapath #(.CNT_W(CNT_W), .BPS_W(BPS_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .lineIn       (lineIn),
    .bitsPerSample(bitsPerSample),
    .ctrl         (ctrl),
    .edgeSeen     (edgeSeen),
    .isShort      (isShort),
    .isLong       (isLong),
    .stalled      (stalled),
    .bitData      (bitData),
    .bitValid     (bitValid),
    .sampleStrobe (sampleStrobe)
  );

  bmcControl u_control (
    .clk     (clk),
    .rstN    (rstN),
    .edgeSeen(edgeSeen),
    .isShort (isShort),
    .isLong  (isLong),
    .stalled (stalled),
    .ctrl    (ctrl),
    .locked  (locked)
  );

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> locked); // R5

  AST_STROBE_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> bitValid); // R6

endmodule

// File: tb/test_bmcRx.sv
module test_bmcRx;

  localparam int BPS_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             lineIn = 1'b0;
  logic [BPS_W-1:0] bitsPerSample = 6'd4;
  logic             bitData, bitValid, sampleStrobe, locked;

  int errors = 0;
  int checks = 0;
  int hp = 8;
  bit done = 1'b0;

  logic rxBits   [0:63];
  logic rxStrobe [0:63];
  int   rxN = 0;
  int   lockRises = 0;
  int   lockFalls = 0;
  int   validUnlocked = 0;
  logic lockedPrev = 1'b0;

  always #2 clk = ~clk;

  bmcRx #(.CNT_W(10), .BPS_W(BPS_W)) i_bmcRx (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .bitsPerSample(bitsPerSample),
    .bitData(bitData), .bitValid(bitValid), .sampleStrobe(sampleStrobe), .locked(locked)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (bitValid && rxN < 64) begin
        rxBits[rxN]   = bitData;
        rxStrobe[rxN] = sampleStrobe;
        rxN++;
      end
      if (bitValid && !locked) validUnlocked++;
      if (locked && !lockedPrev) lockRises++;
      if (!locked && lockedPrev) lockFalls++;
      lockedPrev = locked;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input int bps);
    @(posedge clk); #1;
    rstN = 1'b0; lineIn = 1'b0; bitsPerSample = BPS_W'(bps);
    repeat (5) @(posedge clk);
    #1;
    rxN = 0; lockRises = 0; lockFalls = 0; validUnlocked = 0; lockedPrev = 1'b0;
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic seg(input int n);
    lineIn = ~lineIn;
    repeat (n * hp) @(posedge clk);
    #1;
  endtask

  task automatic sendBit(input bit b);
    if (b) begin seg(1); seg(1); end
    else   seg(2);
  endtask

  task automatic sendPrefix();
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
  endtask

  task automatic testReset();
    @(posedge clk); #1;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!locked && !bitValid && !sampleStrobe, "R1 outputs during reset", {locked, bitValid, sampleStrobe}, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check(!locked, "R1 locked after reset", locked, 0);
    check(!bitValid && !sampleStrobe, "R1 valid/strobe after reset", {bitValid, sampleStrobe}, 0);
  endtask

  task automatic testDecode(input int halfPeriod, input logic [15:0] pat);
    int bad = 0;
    hp = halfPeriod;
    doReset(4);
    sendPrefix();
    for (int i = 0; i < 16; i++) sendBit(pat[i]);
    seg(2);                              // trailing bit closes the last data bit
    check(locked == 1'b1, "R2 locked at rate", halfPeriod, 1);
    check(lockRises == 1, "R2 single lock", lockRises, 1);
    repeat (10 * hp) @(posedge clk);
    #1;
    check(rxN == 16, "R4 bit count", rxN, 16);
    for (int i = 0; i < 16; i++) if (rxBits[i] !== pat[i]) bad++;
    check(bad == 0, "R4 decoded bits mismatching", bad, 0);
    check(validUnlocked == 0, "R5 valid while unlocked", validUnlocked, 0);
    check(locked == 1'b0, "R8 lock dropped on idle line", locked, 0);
  endtask

  task automatic testZeros();
    hp = 8;
    doReset(4);
    for (int i = 0; i < 20; i++) sendBit(1'b0);
    check(lockRises == 0, "R3 lock with zeros only", lockRises, 0);
    check(rxN == 0, "R3 bits with zeros only", rxN, 0);
  endtask

  task automatic testStrobe(input int bps);
    int bad = 0;
    int period;
    hp = 6;
    period = (bps < 2) ? 1 : bps;
    doReset(bps);
    sendPrefix();
    for (int i = 0; i < 12; i++) sendBit(i[0] ^ i[2]);
    seg(2);
    repeat (10 * hp) @(posedge clk);
    #1;
    check(rxN == 12, "R6 bit count", rxN, 12);
    for (int i = 0; i < 12; i++)
      if (rxStrobe[i] !== (((i + 1) % period) == 0)) bad++;
    check(bad == 0, "R6 strobe positions wrong", bad, 0);
  endtask

  task automatic testCodingError();
    logic [7:0] expBits = 8'b1001_1101;    // index 0 = LSB
    int bad = 0;
    int fallsBefore;
    hp = 8;
    doReset(4);
    sendPrefix();
    sendBit(1); sendBit(0); sendBit(1); sendBit(1);
    seg(1); seg(2);                       // short then long: violation
    sendBit(0);                           // relock boundary, not emitted
    sendBit(1); sendBit(0); sendBit(0); sendBit(1);
    seg(2);
    fallsBefore = lockFalls;
    check(fallsBefore == 1, "R7 lock drops on violation", fallsBefore, 1);
    check(lockRises == 2, "R7 relock without new one bit", lockRises, 2);
    check(locked == 1'b1, "R7 locked after relock", locked, 1);
    repeat (10 * hp) @(posedge clk);
    #1;
    check(rxN == 8, "R7 bits emitted around violation", rxN, 8);
    for (int i = 0; i < 8; i++) if (rxBits[i] !== expBits[i]) bad++;
    check(bad == 0, "R7 decoded bits mismatching", bad, 0);
    check(validUnlocked == 0, "R5 valid while unlocked", validUnlocked, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testDecode(8,  16'hA5C3);
    testDecode(5,  16'h3F01);
    testDecode(20, 16'hFFF0);
    testZeros();
    testStrobe(4);
    testStrobe(1);
    testStrobe(0);
    testCodingError();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule